// File: doc/BRIEF.md
# Sticky Level Interrupt Aggregator

This block gathers interrupt events from several unrelated sources and presents them to a host as one level-sensitive request line. Each source line is first registered into the local clock. A rising edge then sets a sticky pending flag for that source. The request line is active while any enabled flag is set, so the host handler keeps being entered until every event has been taken.

The host finds out which sources need service by reading a pending vector. That same read clears exactly the bits it returned. If a new edge sets a flag in the cycle of the read, the set wins and the event is kept. The host decides which pending bit to service first.

An enable mask chooses which flags may drive the request line. A masked source still latches its flag and still shows in the pending vector.

Top module: `irq_aggregator`

## Requirements
- R1: A rising edge on source i, after synchronization, sets pending bit i. A source held high after its edge does not set the bit again once it has been cleared.
- R2: `irqOut` is high exactly when some pending bit is set whose enable bit is also set. It stays high across cycles until a read or a mask change removes every such bit.
- R3: `pendRd` shows the pending vector at all times, with bit i belonging to source i.
- R4: A clock edge with `rdEn` high clears the pending bits that `pendRd` showed in that cycle. Bits newly set in that same cycle are not cleared.
- R5: If a new edge on source i lands in the same cycle as a clearing read of pending bit i, the bit stays set.
- R6: Each source passes through `SYNC_STAGES` (default 2) flip-flops before edge detection. With the default, a source that rises before clock edge 1 sets its pending bit at edge 3 and not before.
- R7: A clock edge with `maskWrEn` high loads `maskWrData` into the enable mask, where bit i enables source i. The mask is visible on `maskRd`. Masked sources still latch and still appear in `pendRd`.
- R8: Further edges from a source whose bit is already pending merge into that one bit, so a single read clears it.
- R9: During and after reset, all pending bits and all mask bits are zero, and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Asynchronous interrupt source lines |
| rdEn | input | 1 | Read strobe: clears the returned pending bits |
| maskWrEn | input | 1 | Enable mask write strobe |
| maskWrData | input | NUM_SRC | New enable mask value |
| pendRd | output | NUM_SRC | Pending vector |
| maskRd | output | NUM_SRC | Current enable mask |
| irqOut | output | 1 | Level-sensitive interrupt request |

## Verification
The hardest case to reach from the ports is a source edge that reaches the pending register on exactly the clock edge where a read clears it. The stimulus gets there by counting the synchronizer latency. It raises a source on a falling edge and asserts the read strobe two cycles later, so the read's clearing edge is the one where the edge-detected pulse arrives. The same timing is used twice. The first run has the colliding source already pending. The second has a different source pending, which shows that the read clears only the bits it captured.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef struct packed {
    logic clrPend;
    logic loadMask;
  } aggStrobe_t;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] riseVec
);

  localparam int LastStage = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LastStage];
    end
  end

  always_comb riseVec = syncQ[LastStage] & ~prevQ;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((riseVec & $past(riseVec)) == '0)); // R1

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_agg_pkg::*;
(
  input  logic       rdEn,
  input  logic       maskWrEn,
  output aggStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.clrPend  = rdEn;
    strobe.loadMask = maskWrEn;
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  aggStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] riseVec,
  input  logic [NUM_SRC-1:0] maskWrData,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pendNext;

  always_comb begin
    clrVec   = strobe.clrPend ? pendQ : '0;
    pendNext = (pendQ & ~clrVec) | riseVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
    end else begin
      pendQ <= pendNext;
      if (strobe.loadMask) maskQ <= maskWrData;
    end
  end

  always_comb irqOut = |(pendQ & maskQ);

  AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((pendQ & $past(riseVec)) == $past(riseVec))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPend |=> ((pendQ & $past(pendQ & ~riseVec)) == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(riseVec)) == '0)); // R1

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobe.clrPend && !strobe.loadMask) |=> irqOut); // R2

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadMask |=> $stable(maskQ)); // R7

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               rdEn,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  output logic [NUM_SRC-1:0] pendRd,
  output logic [NUM_SRC-1:0] maskRd,
  output logic               irqOut
);

  aggStrobe_t         strobe;
  logic [NUM_SRC-1:0] riseVec;

  irq_sync_edge #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sync_edge (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .riseVec(riseVec)
  );

  irq_ctrl i_ctrl (
    .rdEn    (rdEn),
    .maskWrEn(maskWrEn),
    .strobe  (strobe)
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .riseVec   (riseVec),
    .maskWrData(maskWrData),
    .pendQ     (pendRd),
    .maskQ     (maskRd),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcIn = '0;
  logic         rdEn = 1'b0;
  logic         maskWrEn = 1'b0;
  logic [N-1:0] maskWrData = '0;
  logic [N-1:0] pendRd;
  logic [N-1:0] maskRd;
  logic         irqOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NUM_SRC(N), .SYNC_STAGES(2)) i_irq_aggregator (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .rdEn(rdEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .pendRd(pendRd), .maskRd(maskRd), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulseSrc(input int idx);
    @(negedge clk); srcIn[idx] = 1'b1;
    waitCyc(2);     srcIn[idx] = 1'b0;
    waitCyc(4);
  endtask

  task automatic doRead(output logic [N-1:0] val);
    @(negedge clk); rdEn = 1'b1; val = pendRd;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic writeMask(input logic [N-1:0] m);
    @(negedge clk); maskWrEn = 1'b1; maskWrData = m;
    @(negedge clk); maskWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R9", "pending after reset", pendRd, 0);
    check("R9", "mask after reset", maskRd, 0);
    check("R9", "irq after reset", irqOut, 0);
  endtask

  task automatic testLatencyAndLevel();
    logic [N-1:0] v;
    writeMask('1);
    check("R7", "mask readback", maskRd, 8'hFF);
    @(negedge clk); srcIn[0] = 1'b1;
    waitCyc(2);
    check("R6", "bit not set before 3rd edge", pendRd, 0);
    waitCyc(1);
    check("R6", "bit set on 3rd edge", pendRd, 8'h01);
    check("R2", "irq with pending", irqOut, 1);
    doRead(v);
    check("R3", "read value", v, 8'h01);
    check("R4", "cleared after read", pendRd, 0);
    check("R2", "irq low when empty", irqOut, 0);
    waitCyc(5);
    check("R1", "held-high source no reset", pendRd, 0);
    srcIn[0] = 1'b0;
    waitCyc(4);
  endtask

  task automatic testMulti();
    logic [N-1:0] v;
    pulseSrc(1);
    pulseSrc(5);
    check("R3", "two sources pending", pendRd, 8'h22);
    waitCyc(10);
    check("R2", "irq held", irqOut, 1);
    doRead(v);
    check("R3", "read two sources", v, 8'h22);
    check("R4", "both cleared", pendRd, 0);
    check("R2", "irq dropped", irqOut, 0);
  endtask

  task automatic testMask();
    logic [N-1:0] v;
    writeMask(8'h0F);
    check("R7", "mask readback", maskRd, 8'h0F);
    pulseSrc(6);
    check("R7", "masked bit latched", pendRd, 8'h40);
    check("R7", "masked bit no irq", irqOut, 0);
    writeMask(8'hFF);
    check("R2", "irq after unmask", irqOut, 1);
    doRead(v);
    check("R4", "cleared", pendRd, 0);
  endtask

  task automatic testMerge();
    logic [N-1:0] v;
    pulseSrc(3);
    pulseSrc(3);
    check("R8", "merged bit", pendRd, 8'h08);
    doRead(v);
    check("R8", "single read value", v, 8'h08);
    check("R8", "single read clears", pendRd, 0);
    check("R8", "irq low after one read", irqOut, 0);
  endtask

  task automatic collide(input int pendIdx, input int newIdx,
                         output logic [N-1:0] seen);
    pulseSrc(pendIdx);
    @(negedge clk); srcIn[newIdx] = 1'b1;
    waitCyc(2);
    rdEn = 1'b1; seen = pendRd;
    waitCyc(1);
    rdEn = 1'b0;
  endtask

  task automatic testCollision();
    logic [N-1:0] v;
    collide(4, 4, v);
    check("R5", "read before collision", v, 8'h10);
    check("R5", "set wins over clear", pendRd, 8'h10);
    srcIn[4] = 1'b0;
    waitCyc(3);
    doRead(v);
    check("R4", "cleared afterwards", pendRd, 0);
    collide(0, 7, v);
    check("R4", "captured value", v, 8'h01);
    check("R4", "only captured bit cleared", pendRd, 8'h80);
    check("R2", "irq from new bit", irqOut, 1);
    srcIn[7] = 1'b0;
    waitCyc(3);
    doRead(v);
    check("R4", "final clear", pendRd, 0);
  endtask

  initial begin
    waitCyc(3);
    testReset();
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testLatencyAndLevel();
    testMulti();
    testMask();
    testMerge();
    testCollision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule